// File: doc/BRIEF.md
# Table-Stepped Horizontal Line Resampler

This block stretches or shrinks one line of pixels horizontally. Pixels arrive on a valid/ready stream, with a marker on the final pixel of each line. The block holds a two-pixel window: a current pixel and the pixel after it. For each step it blends the two pixels with an 8-bit weight and sends the result out on a second valid/ready stream.

A cyclic step table set by software decides when the block consumes input and when it produces output. No ratio is computed in hardware. Each table entry holds a weight, an advance flag and an emit flag. The table can describe up-scaling (several outputs per input), down-scaling (several inputs per output) or an irregular mix of both. A register port writes the table, the index of the last entry in use, the enable bit and a scale-direction bit. It also reads back the table, the control word and the index of the step most recently processed.

When the enable bit is clear, the block forwards the input stream to the output unchanged.

Top module: `line_rescaler`

## Requirements
- R1: After reset, the control word at address 20 and the index word at address 21 both read 0, so the block is in bypass mode and out_valid follows in_valid, which is low.
- R2: Table entry bit 0 is the emit flag, bit 1 is the advance flag and bits 9:2 hold the weight w. An emitted pixel equals (cur*(256-w) + next*w + 128) >> 8.
- R3: An entry with the advance flag clear reuses the same pixel pair for the following entry. An entry with the advance flag set shifts the window by one input pixel.
- R4: An entry with the emit flag clear produces no output beat, but still steps the table and, if its advance flag is set, consumes input.
- R5: After an entry is processed, the table pointer returns to 0 if the entry was at the last index (control bits 12:8) or at index 19. Otherwise the pointer moves to the next entry.
- R6: While the current pixel is the last pixel of the line, that pixel also serves as the next pixel. An advancing step on the last pixel ends the line, and the next line starts at table index 0.
- R7: While an emitted pixel waits on out_ready low, its value and out_valid stay steady, and no input or table step is lost.
- R8: When control bit 0 is clear, out_valid equals in_valid, out_data equals in_data and in_ready equals out_ready.
- R9: Address 21 reads the index of the last processed table entry in bits 20:16, with bits 4:0 reading 0.
- R10: Address 20 reads back control bits 0 (enable), 1 (up-scale direction) and 12:8 (last index). Addresses 0 to 19 read back the table entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted |
| in_data | input | 8 | Input pixel |
| in_last | input | 1 | Input pixel is the last of its line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | 8 | Output pixel |

## Verification
Two-pixel lines with a single emit-and-advance entry test the blend on its own. The weight extremes 0, 1, 128 and 255 separate the rounding term and the two operand roles. A pair of equal pixels, as seen at line end, shows that the weight has no effect in that case. Three step tables then run: a 2x up-scale, a 2:1 down-scale and an irregular five-entry table padded with decoy entries. These show whether a flag is read from the wrong bit, whether the pointer wraps at the programmed last index or at the table end, and whether a line restarts at entry 0. The irregular table also runs under combined input gaps and output stalls, and the bypass mode is driven with varied handshake patterns.

// File: rtl/line_rescaler.sv
module line_rescaler #(
  parameter int DW    = 8,
  parameter int WW    = 8,
  parameter int TBL_N = 20,
  parameter int AW    = $clog2(TBL_N + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  localparam int IW      = $clog2(TBL_N);
  localparam int EW      = WW + 2;
  localparam int PW      = DW + WW + 1;
  localparam int CTRL_A  = TBL_N;
  localparam int INDEX_A = TBL_N + 1;

  logic [EW-1:0] tbl [TBL_N];
  logic          rs_en, up_dir;
  logic [IW-1:0] last_idx, ptr, hidx;
  logic [DW-1:0] cur, nxt;
  logic          have_cur, have_nxt, cur_last, nxt_last;

  logic [EW-1:0] entry;
  logic          emit, adv, win_rdy, fire, step_adv, room, take, wrap;
  logic [WW-1:0] w;
  logic [DW-1:0] nxt_e, blend;
  logic [PW-1:0] mix;

  assign entry = tbl[ptr];
  assign emit  = entry[0];
  assign adv   = entry[1];
  assign w     = entry[EW-1:2];

  assign nxt_e = have_nxt ? nxt : cur;
  assign mix   = PW'(cur) * (PW'(1) << WW) - PW'(cur) * PW'(w)
               + PW'(nxt_e) * PW'(w) + (PW'(1) << (WW - 1));
  assign blend = DW'(mix >> WW);

  assign win_rdy  = have_cur && (have_nxt || cur_last);
  assign fire     = rs_en && win_rdy && (!emit || out_ready);
  assign step_adv = fire && adv;
  assign wrap     = (ptr == last_idx) || (ptr == IW'(TBL_N - 1));

  assign room = !have_cur || (!have_nxt && !cur_last) ||
                (step_adv && (cur_last || !nxt_last));
  assign in_ready  = rs_en ? room : out_ready;
  assign take      = rs_en && in_valid && room;
  assign out_valid = rs_en ? (win_rdy && emit) : in_valid;
  assign out_data  = rs_en ? blend : in_data;

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr < AW'(TBL_N))
      cfg_rdata = 32'(tbl[cfg_addr[IW-1:0]]);
    else if (cfg_addr == AW'(CTRL_A))
      cfg_rdata = 32'({last_idx, 6'b0, up_dir, rs_en});
    else if (cfg_addr == AW'(INDEX_A))
      cfg_rdata = 32'(hidx) << 16;
  end

  logic unused_wd;
  assign unused_wd = ^cfg_wdata;

  always_ff @(posedge clk)
    if (cfg_we && cfg_addr < AW'(TBL_N))
      tbl[cfg_addr[IW-1:0]] <= cfg_wdata[EW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_en    <= 1'b0;
      up_dir   <= 1'b0;
      last_idx <= '0;
    end else if (cfg_we && cfg_addr == AW'(CTRL_A)) begin
      rs_en    <= cfg_wdata[0];
      up_dir   <= cfg_wdata[1];
      last_idx <= cfg_wdata[8 +: IW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      hidx     <= '0;
      cur      <= '0;
      nxt      <= '0;
      have_cur <= 1'b0;
      have_nxt <= 1'b0;
      cur_last <= 1'b0;
      nxt_last <= 1'b0;
    end else if (rs_en) begin
      if (fire) begin
        hidx <= ptr;
        ptr  <= ((step_adv && cur_last) || wrap) ? '0 : ptr + 1'b1;
      end
      if (step_adv) begin
        if (cur_last) begin
          have_cur <= take;
          cur      <= in_data;
          cur_last <= in_last;
          have_nxt <= 1'b0;
        end else begin
          cur      <= nxt;
          cur_last <= nxt_last;
          have_nxt <= take;
          nxt      <= in_data;
          nxt_last <= in_last;
        end
      end else if (take) begin
        if (!have_cur) begin
          have_cur <= 1'b1;
          cur      <= in_data;
          cur_last <= in_last;
        end else begin
          have_nxt <= 1'b1;
          nxt      <= in_data;
          nxt_last <= in_last;
        end
      end
    end
  end

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wrap) |=> (ptr == '0));

  p_line_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_adv && cur_last) |=> (ptr == '0 && !have_nxt));

  p_hold_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_en && out_valid && !out_ready && !cfg_we) |=> (out_valid && $stable(out_data)));

  p_reuse_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !adv) |=> (have_cur && $stable(cur)));

  p_shift_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_adv && !cur_last) |=> (have_cur && cur == $past(nxt)));
endmodule

// File: tb/line_rescaler_test.sv
module line_rescaler_test;
  logic        clk = 1'b0;
  logic        rst_n, cfg_we, in_valid, in_last, out_ready;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [7:0]  in_data, out_data;
  logic        in_ready, out_valid;

  always #4 clk = ~clk;

  line_rescaler uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  localparam logic [23:0] VEC [8] = '{
    {8'd10,  8'd20,  8'd0},   {8'd10,  8'd20,  8'd255},
    {8'd0,   8'd255, 8'd128}, {8'd255, 8'd0,   8'd128},
    {8'd100, 8'd200, 8'd64},  {8'd37,  8'd91,  8'd1},
    {8'd200, 8'd13,  8'd200}, {8'd255, 8'd255, 8'd255}
  };

  int errs = 0, checks = 0;
  logic [9:0] tb_tbl [20];
  int tb_last, tb_up, n, expn, exp_idx, gotn;
  int px [64];
  int expv [256];
  int got [256];
  logic [31:0] rv;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int mixf(input int a, input int b, input int w);
    return (a * (256 - w) + b * w + 128) >> 8;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = 5'(a);
    #1 v = cfg_rdata;
  endtask

  task automatic model();
    int p = 0, i = 0;
    expn = 0;
    for (int s = 0; s < 1000; s++) begin
      logic [9:0] e;
      int nx;
      e = tb_tbl[p];
      nx = (i == n - 1) ? px[i] : px[i + 1];
      if (e[0]) begin expv[expn] = mixf(px[i], nx, int'(e[9:2])); expn++; end
      exp_idx = p;
      p = (p == tb_last || p == 19) ? 0 : p + 1;
      if (e[1]) begin
        if (i == n - 1) break;
        i++;
      end
    end
  endtask

  task automatic load_tbl();
    for (int k = 0; k < 20; k++) wr(k, 32'(tb_tbl[k]));
    wr(20, 32'((tb_last << 8) | (tb_up << 1) | 1));
  endtask

  task automatic run_line(input int bp, input string rq);
    int k = 0, idle = 0;
    model();
    gotn = 0;
    for (int c = 0; c < 3000 && idle < 20; c++) begin
      @(negedge clk);
      in_valid  = (k < n) && (bp == 0 || c % 4 != 2);
      in_data   = 8'(px[k]);
      in_last   = (k == n - 1);
      out_ready = (bp == 0) || (c % 3 != 1);
      #2;
      if (in_valid && in_ready) k++;
      if (out_valid && out_ready) begin
        if (gotn < 256) got[gotn] = int'(out_data);
        gotn++;
      end
      if (k == n && gotn >= expn) idle++;
    end
    in_valid = 1'b0;
    chk(gotn == expn, rq, gotn, expn);
    for (int i = 0; i < expn && i < gotn; i++) chk(got[i] == expv[i], rq, got[i], expv[i]);
  endtask

  initial begin
    #(8 * 150000);
    checks++; errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1 chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    rd(20, rv); chk(rv == 0, "R1", int'(rv), 0);
    rd(21, rv); chk(rv == 0, "R1", int'(rv), 0);

    // R2 blend formula, single emit-and-advance entry
    tb_up = 0; tb_last = 0;
    for (int k = 0; k < 20; k++) tb_tbl[k] = 10'd0;
    for (int v = 0; v < 8; v++) begin
      tb_tbl[0] = 10'((int'(VEC[v][7:0]) << 2) | 3);
      load_tbl();
      n = 2; px[0] = int'(VEC[v][23:16]); px[1] = int'(VEC[v][15:8]);
      run_line(0, "R2");
    end

    // R3 up-scale by two
    tb_up = 1; tb_last = 1;
    tb_tbl[0] = 10'd1; tb_tbl[1] = 10'((128 << 2) | 3);
    load_tbl();
    n = 4; px[0] = 10; px[1] = 50; px[2] = 90; px[3] = 130;
    run_line(0, "R3");

    // R4 down-scale by two, non-emitting advance entries
    tb_up = 0; tb_last = 1;
    tb_tbl[0] = 10'd2; tb_tbl[1] = 10'((64 << 2) | 3);
    load_tbl();
    n = 8;
    for (int i = 0; i < 8; i++) px[i] = 20 + 29 * i;
    run_line(0, "R4");
    chk(expn == 4, "R4", expn, 4);

    // R5 wrap at programmed last index, decoy entries beyond it
    tb_last = 4;
    tb_tbl[0] = 10'((40 << 2) | 3);  tb_tbl[1] = 10'd2;
    tb_tbl[2] = 10'((180 << 2) | 1); tb_tbl[3] = 10'((255 << 2) | 3);
    tb_tbl[4] = 10'((77 << 2) | 3);
    for (int k = 5; k < 20; k++) tb_tbl[k] = 10'((99 << 2) | 1);
    load_tbl();
    n = 12;
    for (int i = 0; i < 12; i++) px[i] = (i * 53 + 7) % 256;
    run_line(0, "R5");
    // R9 index of last processed entry
    rd(21, rv); chk(rv == 32'(exp_idx << 16), "R9", int'(rv), exp_idx << 16);

    // R7 same line under input gaps and output stalls
    run_line(1, "R7");

    // R5 last index beyond table end wraps at 19
    tb_last = 31;
    for (int k = 0; k < 20; k++) tb_tbl[k] = 10'(((k * 12) << 2) | 3);
    load_tbl();
    n = 25;
    for (int i = 0; i < 25; i++) px[i] = (i * 97 + 3) % 256;
    run_line(0, "R5");

    // R6 consecutive lines restart at entry 0, last pixel replicated
    tb_last = 2;
    tb_tbl[0] = 10'((30 << 2) | 3); tb_tbl[1] = 10'((200 << 2) | 1);
    tb_tbl[2] = 10'((90 << 2) | 3);
    load_tbl();
    n = 3; px[0] = 5; px[1] = 250; px[2] = 120;
    run_line(0, "R6");
    n = 5; px[0] = 60; px[1] = 0; px[2] = 255; px[3] = 33; px[4] = 180;
    run_line(0, "R6");
    rd(21, rv); chk(rv == 32'(exp_idx << 16), "R9", int'(rv), exp_idx << 16);

    // R10 readback of control and table
    wr(20, 32'((7 << 8) | 3));
    rd(20, rv); chk(rv == 32'h0703, "R10", int'(rv), 32'h0703);
    rd(2, rv); chk(rv == 32'(tb_tbl[2]), "R10", int'(rv), int'(tb_tbl[2]));

    // R8 bypass
    wr(20, 32'h0000_0102);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      in_valid = c[0]; in_data = 8'(c * 41 + 9); out_ready = c[1];
      #2;
      chk(out_valid == in_valid, "R8", int'(out_valid), int'(in_valid));
      chk(out_data == in_data, "R8", int'(out_data), int'(in_data));
      chk(in_ready == out_ready, "R8", int'(in_ready), int'(out_ready));
    end
    in_valid = 1'b0;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule